// File: doc/BRIEF.md
# Zero-Suppressed Trigger Event Formatter

This block turns one readout card's trigger data into a stream of 32-bit words for a byte-wide serial front-end link. It can build two kinds of event. Both kinds open with the same 32-bit header word. A heartbeat event adds the four per-pair input mask words as status. A self-triggered physics event adds only those strip-pattern words that are not zero. A present-word mask in the header shows which words follow.

A request pulse takes a snapshot of all inputs in the cycle the request is sampled. A small formatter writes the event into a word FIFO at one word per cycle. A serializer then drains the FIFO at one byte per clock, most significant byte first. Each strip pair is packed as one word, with X in bits 31:16 and Y in bits 15:0. Pair 4 is index 3 of the input arrays and pair 1 is index 0.

Top module: `evt_formatter`

## Requirements
- R1: After reset, and until the first request, `byte_valid_o` stays 0.
- R2: The header word is laid out as follows: bit 31 is a start bit that is always 1. Bit 30 is busy, equal to `fifo_full_i`. Bit 29 is the decision, equal to `decision_i`. Bit 28 is the card type, equal to parameter `CARD_LOCAL` (default 1). Bit 27 is heartbeat. Bit 26 is acquisition. Bits 25:24 hold the run code. Bits 23:8 hold `bunch_i`. Bits 7:4 hold `position_i`. Bits 3:0 hold the present-word mask, where bit k stands for pair index k.
- R3: A heartbeat event is the header followed by four words: `mask_i[3]`, `mask_i[2]`, `mask_i[1]`, `mask_i[0]`, 5 words in all. In its header, heartbeat = 1, acquisition = `acq_on_i`, run code = `run_code_i` (11 reset, 10 end of run, 01 start of run, 00 other), and present mask = 1111.
- R4: A physics event is the header followed only by the non-zero words `strip_i[k]`, taken for k from 3 down to 0. In its header, heartbeat = 0, acquisition = 1, run code = 00, and present-mask bit k = (`strip_i[k]` != 0).
- R5: A physics event whose four strip words are all zero is sent as the header word alone.
- R6: Each word is sent as 4 bytes, most significant first. Within one event, `byte_valid_o` stays high in every cycle from the first byte to the last, so a heartbeat takes 20 consecutive clocks.
- R7: If a heartbeat request and a physics request arrive in the same cycle, the heartbeat event is sent complete before the physics event.
- R8: A request of one kind that arrives while an event of the same kind is still pending or being formatted is ignored.
- R9: The event content comes from the inputs in the cycle its request is sampled. Input changes after that cycle do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hb_req_i | input | 1 | Heartbeat event request pulse |
| ph_req_i | input | 1 | Physics event request pulse |
| run_code_i | input | 2 | Run code for heartbeat events |
| acq_on_i | input | 1 | Acquisition state for heartbeat events |
| decision_i | input | 1 | Tracklet decision |
| fifo_full_i | input | 1 | Acquisition FIFO full, sent as busy |
| bunch_i | input | 16 | Bunch counter |
| position_i | input | 4 | Board position |
| mask_i | input | 4x32 | Per-pair input masks, index 3 = pair 4 |
| strip_i | input | 4x32 | Per-pair strip patterns {X,Y}, index 3 = pair 4 |
| byte_o | output | 8 | Serial output byte |
| byte_valid_o | output | 1 | Byte valid |

## Verification
Two things can coincide in one cycle: a heartbeat request and a physics request. The bench raises both request pins on the same clock edge. It then changes the strip inputs on the next cycle. The test passes if the captured byte stream holds the full heartbeat event first, followed by the physics event built from the strip values at the request edge. A second heartbeat request is also sent while the first is still being formatted, and it must leave no trace in the stream.

// File: rtl/evt_fmt_pkg.sv
package evt_fmt_pkg;
  localparam int PAIRS  = 4;
  localparam int WORD_W = 32;
  localparam int BC_W   = 16;
  localparam int POS_W  = 4;
  localparam int IDX_W  = $clog2(PAIRS);
  localparam int EVT_WORDS = PAIRS + 1;

  typedef enum logic [1:0] {FS_IDLE, FS_HDR, FS_DATA} fmt_state_e;

  typedef struct packed {
    logic             start;
    logic             busy;
    logic             decision;
    logic             card_local;
    logic             heartbeat;
    logic             acq;
    logic [1:0]       run_code;
    logic [BC_W-1:0]  bunch;
    logic [POS_W-1:0] position;
    logic [PAIRS-1:0] present;
  } hdr_t;
endpackage

// File: rtl/evt_hdr_build.sv
module evt_hdr_build
  import evt_fmt_pkg::*;
#(
  parameter bit HEARTBEAT  = 1'b1,
  parameter bit CARD_LOCAL = 1'b1
) (
  input  logic                          busy_i,
  input  logic                          decision_i,
  input  logic                          acq_i,
  input  logic [1:0]                    run_code_i,
  input  logic [BC_W-1:0]               bunch_i,
  input  logic [POS_W-1:0]              position_i,
  input  logic [PAIRS-1:0][WORD_W-1:0]  words_i,
  output logic [WORD_W-1:0]             hdr_o
);
  logic [PAIRS-1:0] present;
  hdr_t h;

  generate
    if (HEARTBEAT) begin : g_hb
      assign present = '1;
      logic unused_words;
      assign unused_words = ^words_i;
    end else begin : g_ph
      for (genvar k = 0; k < PAIRS; k++) begin : g_nz
        assign present[k] = |words_i[k];
      end
    end
  endgenerate

  always_comb begin
    h.start      = 1'b1;
    h.busy       = busy_i;
    h.decision   = decision_i;
    h.card_local = CARD_LOCAL;
    h.heartbeat  = HEARTBEAT;
    h.acq        = HEARTBEAT ? acq_i : 1'b1;
    h.run_code   = HEARTBEAT ? run_code_i : 2'b00;
    h.bunch      = bunch_i;
    h.position   = position_i;
    h.present    = present;
    hdr_o        = h;
  end
endmodule

// File: rtl/evt_word_fifo.sv
module evt_word_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      lvl_q <= lvl_q + 1'b1;
      else if (pop_i && !push_i) lvl_q <= lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign empty_o = (lvl_q == '0);
  assign level_o = lvl_q;

  // R3/R4: whole events fit, so the formatter never overruns the FIFO
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> lvl_q < LVL_W'(DEPTH));
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/evt_byte_ser.sv
module evt_byte_ser #(
  parameter int W = 32,
  localparam int BYTES = W / 8,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         empty_i,
  output logic         pop_o,
  output logic [7:0]   byte_o,
  output logic         byte_valid_o
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  // fetch next word while the last byte of the current one leaves
  assign pop_o = !empty_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q         <= '0;
      cnt_q        <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      if (cnt_q != '0) begin
        byte_o       <= sh_q[W-1 -: 8];
        byte_valid_o <= 1'b1;
      end else if (!empty_i) begin
        byte_o       <= word_i[W-1 -: 8];
        byte_valid_o <= 1'b1;
      end else begin
        byte_valid_o <= 1'b0;
      end
      if (pop_o) begin
        if (cnt_q == CNT_W'(1)) begin
          sh_q  <= word_i;
          cnt_q <= CNT_W'(BYTES);
        end else begin
          sh_q  <= word_i << 8;
          cnt_q <= CNT_W'(BYTES - 1);
        end
      end else if (cnt_q != '0) begin
        sh_q  <= sh_q << 8;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r6_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0 |=> byte_valid_o);
endmodule

// File: rtl/evt_formatter.sv
module evt_formatter
  import evt_fmt_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter bit CARD_LOCAL = 1'b1,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hb_req_i,
  input  logic                         ph_req_i,
  input  logic [1:0]                   run_code_i,
  input  logic                         acq_on_i,
  input  logic                         decision_i,
  input  logic                         fifo_full_i,
  input  logic [BC_W-1:0]              bunch_i,
  input  logic [POS_W-1:0]             position_i,
  input  logic [PAIRS-1:0][WORD_W-1:0] mask_i,
  input  logic [PAIRS-1:0][WORD_W-1:0] strip_i,
  output logic [7:0]                   byte_o,
  output logic                         byte_valid_o
);
  logic [WORD_W-1:0] hb_hdr_d, ph_hdr_d;
  logic [WORD_W-1:0] hb_hdr_q, ph_hdr_q;
  logic [PAIRS-1:0][WORD_W-1:0] hb_dat_q, ph_dat_q;
  logic hb_pend_q, ph_pend_q, cur_hb_q;
  fmt_state_e st_q;
  logic [PAIRS-1:0] rem_q;

  logic              push, pop, f_empty;
  logic [WORD_W-1:0] push_word, f_rdata;
  logic [LVL_W-1:0]  f_level;

  evt_hdr_build #(.HEARTBEAT(1'b1), .CARD_LOCAL(CARD_LOCAL)) u_hb_hdr (
    .busy_i(fifo_full_i), .decision_i(decision_i), .acq_i(acq_on_i),
    .run_code_i(run_code_i), .bunch_i(bunch_i), .position_i(position_i),
    .words_i(mask_i), .hdr_o(hb_hdr_d));

  evt_hdr_build #(.HEARTBEAT(1'b0), .CARD_LOCAL(CARD_LOCAL)) u_ph_hdr (
    .busy_i(fifo_full_i), .decision_i(decision_i), .acq_i(acq_on_i),
    .run_code_i(run_code_i), .bunch_i(bunch_i), .position_i(position_i),
    .words_i(strip_i), .hdr_o(ph_hdr_d));

  logic active_hb, active_ph, hb_take, ph_take, can_accept, start_hb, start_ph;
  assign active_hb  = (st_q != FS_IDLE) && cur_hb_q;
  assign active_ph  = (st_q != FS_IDLE) && !cur_hb_q;
  assign hb_take    = hb_req_i && !hb_pend_q && !active_hb;
  assign ph_take    = ph_req_i && !ph_pend_q && !active_ph;
  assign can_accept = (st_q == FS_IDLE) && (f_level <= LVL_W'(FIFO_DEPTH - EVT_WORDS));
  assign start_hb   = can_accept && hb_pend_q;
  assign start_ph   = can_accept && !hb_pend_q && ph_pend_q;

  function automatic logic [IDX_W-1:0] top_set(input logic [PAIRS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < PAIRS; k++) if (m[k]) r = IDX_W'(k);
    return r;
  endfunction

  logic [IDX_W-1:0] idx;
  logic [PAIRS-1:0] rem_nxt;
  always_comb begin
    idx       = top_set(rem_q);
    rem_nxt   = rem_q;
    rem_nxt[idx] = 1'b0;
    push      = (st_q == FS_HDR) || (st_q == FS_DATA);
    if (st_q == FS_HDR) push_word = cur_hb_q ? hb_hdr_q : ph_hdr_q;
    else                push_word = cur_hb_q ? hb_dat_q[idx] : ph_dat_q[idx];
  end

  // snapshots taken in the request cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_hdr_q <= '0;
      ph_hdr_q <= '0;
      hb_dat_q <= '0;
      ph_dat_q <= '0;
    end else begin
      if (hb_take) begin
        hb_hdr_q <= hb_hdr_d;
        hb_dat_q <= mask_i;
      end
      if (ph_take) begin
        ph_hdr_q <= ph_hdr_d;
        ph_dat_q <= strip_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_pend_q <= 1'b0;
      ph_pend_q <= 1'b0;
      cur_hb_q  <= 1'b0;
      st_q      <= FS_IDLE;
      rem_q     <= '0;
    end else begin
      if (hb_take)       hb_pend_q <= 1'b1;
      else if (start_hb) hb_pend_q <= 1'b0;
      if (ph_take)       ph_pend_q <= 1'b1;
      else if (start_ph) ph_pend_q <= 1'b0;
      case (st_q)
        FS_IDLE: if (start_hb || start_ph) begin
          cur_hb_q <= start_hb;
          st_q     <= FS_HDR;
        end
        FS_HDR: begin
          rem_q <= push_word[PAIRS-1:0];
          st_q  <= (push_word[PAIRS-1:0] == '0) ? FS_IDLE : FS_DATA;
        end
        FS_DATA: begin
          rem_q <= rem_nxt;
          if (rem_nxt == '0) st_q <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  evt_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .wdata_i(push_word),
    .pop_i(pop), .rdata_o(f_rdata), .empty_o(f_empty), .level_o(f_level));

  evt_byte_ser #(.W(WORD_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(f_rdata), .empty_i(f_empty),
    .pop_o(pop), .byte_o(byte_o), .byte_valid_o(byte_valid_o));

  a_r2_hdr_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == FS_HDR |-> push_word[31] && (push_word[27] == cur_hb_q)
                       && (push_word[28] == CARD_LOCAL));
  a_r4_ph_hdr_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == FS_HDR && !cur_hb_q |-> push_word[26] && push_word[25:24] == 2'b00);
  a_r4_no_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == FS_DATA && !cur_hb_q |-> push_word != '0);
  a_r7_hb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    can_accept && hb_pend_q && ph_pend_q |=> cur_hb_q && st_q == FS_HDR);
  a_r8_no_hb_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_hb |-> !hb_pend_q);
endmodule

// File: tb/evt_formatter_test.sv
module evt_formatter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic hb_req = 0, ph_req = 0, acq_on = 0, decision = 0, fifo_full = 0;
  logic [1:0]  run_code = 0;
  logic [15:0] bunch = 0;
  logic [3:0]  position = 0;
  logic [3:0][31:0] mask = '0, strip = '0;
  logic [7:0] byte_o;
  logic byte_valid;

  evt_formatter uut (
    .clk_i(clk), .rst_ni(rst_n), .hb_req_i(hb_req), .ph_req_i(ph_req),
    .run_code_i(run_code), .acq_on_i(acq_on), .decision_i(decision),
    .fifo_full_i(fifo_full), .bunch_i(bunch), .position_i(position),
    .mask_i(mask), .strip_i(strip), .byte_o(byte_o), .byte_valid_o(byte_valid));

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] cap_b [0:127];
  int cap_t [0:127];
  int cap_n = 0;
  logic [31:0] exp_w [0:31];
  logic exp_first [0:31];
  int exp_n = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && byte_valid && cap_n < 128) begin
    cap_b[cap_n] = byte_o;
    cap_t[cap_n] = cyc;
    cap_n++;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic hb, input logic [3:0] pres);
    return {1'b1, fifo_full, decision, 1'b1, hb, hb ? acq_on : 1'b1,
            hb ? run_code : 2'b00, bunch, position, pres};
  endfunction

  task automatic exp_hb();
    exp_w[exp_n] = hdr(1'b1, 4'hF); exp_first[exp_n] = 1; exp_n++;
    for (int k = 3; k >= 0; k--) begin
      exp_w[exp_n] = mask[k]; exp_first[exp_n] = 0; exp_n++;
    end
  endtask

  task automatic exp_ph();
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = (strip[k] != 0);
    exp_w[exp_n] = hdr(1'b0, p); exp_first[exp_n] = 1; exp_n++;
    for (int k = 3; k >= 0; k--) if (p[k]) begin
      exp_w[exp_n] = strip[k]; exp_first[exp_n] = 0; exp_n++;
    end
  endtask

  task automatic clear();
    cap_n = 0;
    exp_n = 0;
  endtask

  task automatic pulse(input logic hb, input logic ph);
    @(negedge clk);
    hb_req = hb; ph_req = ph;
    @(negedge clk);
    hb_req = 0; ph_req = 0;
  endtask

  task automatic compare(input string req);
    chk({req, " byte count"}, cap_n, exp_n * 4);
    for (int i = 0; i < exp_n && (i * 4 + 3) < cap_n; i++) begin
      chk(req, {cap_b[4*i], cap_b[4*i+1], cap_b[4*i+2], cap_b[4*i+3]}, exp_w[i]);
      for (int j = 0; j < 4; j++) begin
        int b = 4 * i + j;
        if (b > 0 && !(j == 0 && exp_first[i]))
          chk({req, " R6 gap"}, cap_t[b] - cap_t[b-1], 1);
      end
    end
  endtask

  task automatic t_reset();
    clear();
    repeat (10) begin
      @(negedge clk);
      chk("R1 valid after reset", byte_valid, 0);
    end
    chk("R1 nothing sent", cap_n, 0);
  endtask

  task automatic t_hb_basic();
    clear();
    mask = {32'hA1A2_A3A4, 32'h0000_0000, 32'h1122_3344, 32'hF0F0_0F0F};
    run_code = 2'b01; acq_on = 1; fifo_full = 0; decision = 0;
    bunch = 16'h1234; position = 4'd5;
    exp_hb();
    pulse(1, 0);
    repeat (40) @(negedge clk);
    compare("R3 heartbeat");
    chk("R6 heartbeat 20 bytes", cap_t[19] - cap_t[0], 19);
  endtask

  task automatic t_hb_flags();
    clear();
    run_code = 2'b11; acq_on = 0; fifo_full = 1; decision = 1;
    bunch = 16'hFFFF; position = 4'd15;
    exp_hb();
    pulse(1, 0);
    repeat (40) @(negedge clk);
    compare("R2 header flags");
    fifo_full = 0;
  endtask

  task automatic t_ph_sparse();
    clear();
    strip = {32'h8001_0000, 32'h0, 32'h0, 32'h0000_0001};
    decision = 1; bunch = 16'h00AB; position = 4'd3; run_code = 2'b10; acq_on = 0;
    exp_ph();
    pulse(0, 1);
    repeat (30) @(negedge clk);
    compare("R4 physics sparse");
  endtask

  task automatic t_ph_full();
    clear();
    strip = {32'h1, 32'h2000_0000, 32'hDEAD_BEEF, 32'h0001_0000};
    decision = 0; bunch = 16'h5A5A; position = 4'd9;
    exp_ph();
    pulse(0, 1);
    repeat (40) @(negedge clk);
    compare("R4 physics full");
  endtask

  task automatic t_ph_empty();
    clear();
    strip = '0; bunch = 16'h0F0F; position = 4'd0;
    exp_ph();
    pulse(0, 1);
    repeat (20) @(negedge clk);
    compare("R5 empty physics");
  endtask

  task automatic t_collision();
    clear();
    mask = {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444};
    strip = {32'h0, 32'hCAFE_0000, 32'h0, 32'h0000_BABE};
    run_code = 2'b00; acq_on = 1; bunch = 16'h0777; position = 4'd7;
    exp_hb();
    exp_ph();
    pulse(1, 1);
    strip = {32'hFFFF_FFFF, 32'h0, 32'h1, 32'h2};
    repeat (60) @(negedge clk);
    compare("R7 heartbeat before physics");
  endtask

  task automatic t_repeat_drop();
    clear();
    mask = {32'h0102_0304, 32'h0506_0708, 32'h090A_0B0C, 32'h0D0E_0F00};
    bunch = 16'h2222; position = 4'd2;
    exp_hb();
    pulse(1, 0);
    mask = '1;
    pulse(1, 0);
    repeat (40) @(negedge clk);
    compare("R8 repeat heartbeat ignored");
  endtask

  task automatic t_snapshot();
    clear();
    strip = {32'h0, 32'h0, 32'h7777_0000, 32'h0};
    bunch = 16'h3030; position = 4'd12; decision = 1;
    exp_ph();
    @(negedge clk);
    ph_req = 1;
    @(negedge clk);
    ph_req = 0;
    strip = {32'h9, 32'h9, 32'h9, 32'h9}; bunch = 16'h0; position = 4'd1; decision = 0;
    repeat (30) @(negedge clk);
    compare("R9 snapshot at request");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hb_basic();
    t_hb_flags();
    t_ph_sparse();
    t_ph_full();
    t_ph_empty();
    t_collision();
    t_repeat_drop();
    t_snapshot();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule